// File: doc/BRIEF.md
# Sequential Stream Accumulator Kernel

This block is a job-driven streaming kernel placed between two first-in first-out buffers. A one-cycle start pulse begins a job and captures a word count. The kernel then takes that many words from its input buffer, one at a time and in order. After each word it produces the running total of the words taken so far in the job, and it pushes that total into its output buffer. The input and output ports have no addresses. The input side is only read and the output side is only written.

The kernel waits whenever it needs a word and the input buffer reports nothing available. It also waits whenever it holds a result and the output buffer reports no room. A result is placed on the output data port as soon as it is computed, even while the output buffer is full. The write strobe follows only when room appears. The final write of a job carries an end-of-job flag. A one-cycle completion pulse comes on the next cycle, and the kernel is then ready for another start.

Top module: `seqstream_kernel`

## Requirements
- R1: While reset is held and directly after it, `in_rd`, `out_wr`, `out_last` and `done` are low and `out_data` is zero.
- R2: A `start` pulse in the idle state begins a job and captures `cfg_len` as the word count. A `start` pulse, or a change of `cfg_len`, during a running job has no effect on that job's length, data or timing.
- R3: While the kernel is waiting for a word, `in_rd` equals `in_not_empty` in the same cycle, so a word is taken in the first cycle one is available. `in_rd` is never high while `in_not_empty` is low.
- R4: Result k of a job (k counted from 0) equals the sum of input words 0 through k of that job, modulo 2^DATA_W.
- R5: From the cycle after the read that produces a result, that result is on `out_data`, even while `out_not_full` is low. It stays unchanged until the cycle of its write strobe.
- R6: While a result is pending, `out_wr` equals `out_not_full`, and `out_wr` is never high while `out_not_full` is low. The kernel holds at most one word in flight: it performs no read between a read and that read's write, and no write without a read before it.
- R7: `out_last` is high exactly in the cycle of the job's final write strobe. It is low in every other cycle.
- R8: `done` is high for exactly one cycle, the cycle after the final write. In the next cycle the kernel is idle and raises no strobe, even when the input buffer has data.
- R9: A job whose `cfg_len` is 0 performs no read and no write, and raises `done` in the cycle after `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Begin-job pulse, accepted only while idle |
| cfg_len | input | LEN_W | Number of words in the job, captured with start |
| done | output | 1 | One-cycle job-complete pulse |
| in_data | input | DATA_W | Head word of the input buffer |
| in_not_empty | input | 1 | High when the input buffer holds a word |
| in_rd | output | 1 | Takes the head word in this cycle |
| out_data | output | DATA_W | Current result word |
| out_not_full | input | 1 | High when the output buffer has room |
| out_wr | output | 1 | Pushes `out_data` in this cycle |
| out_last | output | 1 | Marks the final write of a job |

## Verification
The assertions assume that the neighbouring buffers behave like first-in first-out queues. `in_data` must be valid whenever `in_not_empty` is high, and both flags may change in any cycle without depending on the strobes of the same cycle. The bench models both buffers so that they keep this contract. The input flag is set only while words remain in the model queue, and a stall pattern may lower it further. Data and flags change on the falling edge, and a stall pattern may lower either flag in any cycle. `start` and `cfg_len` also change only on the falling edge, so a pulse during a job lands in every possible kernel phase.

// File: rtl/seqstream_pkg.sv
package seqstream_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FETCH = 2'd1,
    PH_EMIT  = 2'd2,
    PH_FIN   = 2'd3
  } phase_e;

endpackage

// File: rtl/seqstream_beatcnt.sv
module seqstream_beatcnt #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             final_o
);

  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr_i | inc_i;
    cnt_d  = clr_i ? '0 : cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      cnt_q <= '0;
    end else begin
      if (clr_i) len_q <= len_i;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  // Writes completed so far equal count minus one: the pending write is the final one.
  assign final_o = (cnt_q == (len_q - ONE));

endmodule

// File: rtl/seqstream_accum.sv
module seqstream_accum #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] total_o
);

  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] acc_d;
  logic              acc_en;

  always_comb begin
    acc_en = clr_i | load_i;
    acc_d  = clr_i ? '0 : acc_q + word_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  assign total_o = acc_q;

endmodule

// File: rtl/seqstream_ctrl.sv
module seqstream_ctrl
  import seqstream_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             in_ne_i,
  input  logic             out_nf_i,
  input  logic             final_i,
  output logic             clr_o,
  output logic             rd_o,
  output logic             wr_o,
  output logic             last_o,
  output logic             done_o,
  output logic             ph_idle_o,
  output logic             ph_emit_o
);

  phase_e ph_q;
  phase_e ph_d;
  logic   len_zero;

  assign len_zero = (len_i == '0);

  always_comb begin
    ph_d   = ph_q;
    clr_o  = 1'b0;
    rd_o   = 1'b0;
    wr_o   = 1'b0;
    last_o = 1'b0;
    done_o = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (start_i) begin
          clr_o = 1'b1;
          ph_d  = len_zero ? PH_FIN : PH_FETCH;
        end
      end
      PH_FETCH: begin
        if (in_ne_i) begin
          rd_o = 1'b1;
          ph_d = PH_EMIT;
        end
      end
      PH_EMIT: begin
        if (out_nf_i) begin
          wr_o = 1'b1;
          if (final_i) begin
            last_o = 1'b1;
            ph_d   = PH_FIN;
          end else begin
            ph_d = PH_FETCH;
          end
        end
      end
      PH_FIN: begin
        done_o = 1'b1;
        ph_d   = PH_IDLE;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;
    end else begin
      ph_q <= ph_d;
    end
  end

  assign ph_idle_o = (ph_q == PH_IDLE);
  assign ph_emit_o = (ph_q == PH_EMIT);

endmodule

// File: rtl/seqstream_kernel.sv
module seqstream_kernel #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  cfg_len,
  output logic              done,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_not_empty,
  output logic              in_rd,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_not_full,
  output logic              out_wr,
  output logic              out_last
);

  logic rst_meta_q;
  logic rst_sync_n;
  logic clr;
  logic final_beat;
  logic phase_idle;
  logic phase_emit;

  // Reset asserts at once and releases two edges later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  seqstream_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start_i   (start),
    .len_i     (cfg_len),
    .in_ne_i   (in_not_empty),
    .out_nf_i  (out_not_full),
    .final_i   (final_beat),
    .clr_o     (clr),
    .rd_o      (in_rd),
    .wr_o      (out_wr),
    .last_o    (out_last),
    .done_o    (done),
    .ph_idle_o (phase_idle),
    .ph_emit_o (phase_emit)
  );

  seqstream_beatcnt #(.LEN_W(LEN_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr_i   (clr),
    .inc_i   (out_wr),
    .len_i   (cfg_len),
    .final_o (final_beat)
  );

  seqstream_accum #(.DATA_W(DATA_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr_i   (clr),
    .load_i  (in_rd),
    .word_i  (in_data),
    .total_o (out_data)
  );

endmodule

// File: rtl/seqstream_kernel_chk.sv
module seqstream_kernel_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_rd,
  input logic              in_not_empty,
  input logic              out_wr,
  input logic              out_not_full,
  input logic              out_last,
  input logic              done,
  input logic [DATA_W-1:0] out_data,
  input logic              phase_idle,
  input logic              phase_emit
);

  AST_RD_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    in_rd |-> in_not_empty); // R3

  AST_WR_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr |-> out_not_full); // R6

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    in_rd |=> (!in_rd && phase_emit)); // R6

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_emit && !out_wr) |=> $stable(out_data)); // R5

  AST_LAST_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_wr); // R7

  AST_DONE_FOLLOWS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> done); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && phase_idle)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    phase_idle |-> (!in_rd && !out_wr && !out_last)); // R2

endmodule

bind seqstream_kernel seqstream_kernel_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .in_rd        (in_rd),
  .in_not_empty (in_not_empty),
  .out_wr       (out_wr),
  .out_not_full (out_not_full),
  .out_last     (out_last),
  .done         (done),
  .out_data     (out_data),
  .phase_idle   (phase_idle),
  .phase_emit   (phase_emit)
);

// File: tb/seqstream_kernel_test.sv
module seqstream_kernel_test;

  localparam int DW = 16;
  localparam int LW = 8;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [LW-1:0] cfg_len;
  logic          done;
  logic [DW-1:0] in_data;
  logic          in_not_empty;
  logic          in_rd;
  logic [DW-1:0] out_data;
  logic          out_not_full;
  logic          out_wr;
  logic          out_last;

  int n_tests;
  int n_fail;
  logic [DW-1:0] src [0:255];

  seqstream_kernel #(.DATA_W(DW), .LEN_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_len(cfg_len), .done(done),
    .in_data(in_data), .in_not_empty(in_not_empty), .in_rd(in_rd),
    .out_data(out_data), .out_not_full(out_not_full), .out_wr(out_wr),
    .out_last(out_last)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit in_stall(input int mode, input int c);
    case (mode)
      1: in_stall = (c % 3) == 0;
      2: in_stall = (c % 2) == 1;
      3: in_stall = ((c / 3) % 2) == 0;
      default: in_stall = 1'b0;
    endcase
  endfunction

  function automatic bit out_full(input int mode, input int c);
    case (mode)
      1: out_full = (c % 2) == 0;
      2: out_full = (c % 3) != 0;
      3: out_full = ((c / 4) % 2) == 0;
      default: out_full = 1'b0;
    endcase
  endfunction

  task automatic run_job(input int len, input int imode, input int omode,
                         input int seed, input bit poke);
    int rd_n;
    int wr_n;
    int cyc;
    bit pend;
    bit pend0;
    bit done_exp;
    bit seen_done;
    logic [DW-1:0] ref_sum;
    for (int i = 0; i < len; i++) src[i] = DW'(i * 37 + seed * 113 + 3855 + i * i * 5);
    rd_n = 0; wr_n = 0; cyc = 0; pend = 1'b0; seen_done = 1'b0; ref_sum = '0;
    done_exp = (len == 0);
    @(negedge clk);
    start = 1'b1; cfg_len = LW'(len); in_not_empty = 1'b0; out_not_full = 1'b0;
    #1;
    chk(!in_rd && !out_wr && !done, "R2 idle before start", int'(in_rd), 0);
    while (!seen_done && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      start = poke && (cyc == 3);
      cfg_len = poke ? LW'(len + 5) : LW'(len);
      in_not_empty = (rd_n < len) && !in_stall(imode, cyc);
      in_data = (rd_n < len) ? src[rd_n] : DW'(16'hDEAD);
      out_not_full = !out_full(omode, cyc);
      #1;
      pend0 = pend;
      chk(done == done_exp, "R8/R9 done timing", int'(done), int'(done_exp));
      if (done) seen_done = 1'b1;
      done_exp = 1'b0;
      chk(out_last == (out_wr && wr_n == len - 1), "R7 last flag", int'(out_last),
          int'(out_wr && wr_n == len - 1));
      if (pend0) begin
        chk(out_data == ref_sum, "R4/R5 result on port", int'(out_data), int'(ref_sum));
        chk(out_wr == out_not_full, "R6 write when room", int'(out_wr), int'(out_not_full));
        chk(!in_rd, "R6 no read while pending", int'(in_rd), 0);
        if (out_wr) begin
          wr_n++;
          pend = 1'b0;
          if (wr_n == len) done_exp = 1'b1;
        end
      end else begin
        chk(!out_wr, "R6 no write without read", int'(out_wr), 0);
        if (rd_n < len && !seen_done)
          chk(in_rd == in_not_empty, "R3 read when data", int'(in_rd), int'(in_not_empty));
        else
          chk(!in_rd, "R3 no extra read", int'(in_rd), 0);
        if (in_rd) begin
          ref_sum = ref_sum + in_data;
          rd_n++;
          pend = 1'b1;
        end
      end
    end
    chk(seen_done, "R8 job finished", int'(seen_done), 1);
    chk(rd_n == len && wr_n == len, "R2 transfer count", wr_n, len);
    @(negedge clk);
    start = 1'b0; in_not_empty = 1'b1; in_data = 16'h1234; out_not_full = 1'b1;
    #1;
    chk(!in_rd && !out_wr && !done && !out_last, "R8 idle after done", int'(in_rd), 0);
  endtask

  initial begin
    #(200000 * 4);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int seed;
    n_tests = 0; n_fail = 0;
    rst_n = 1'b0; start = 1'b0; cfg_len = '0; in_data = '0;
    in_not_empty = 1'b1; out_not_full = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(!in_rd && !out_wr && !done && !out_last && out_data == '0, "R1 in reset",
        int'(out_data), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(!in_rd && !out_wr && !done && !out_last && out_data == '0, "R1 after reset",
        int'(out_data), 0);
    seed = 0;
    for (int len = 0; len <= 5; len++) begin
      for (int im = 0; im < 4; im++) begin
        for (int om = 0; om < 4; om++) begin
          seed++;
          run_job(len, im, om, seed, ((len + im + om) % 3) == 0);
        end
      end
    end
    run_job(255, 0, 0, 500, 1'b0);
    run_job(255, 2, 3, 501, 1'b1);
    run_job(0, 1, 1, 502, 1'b0);   // R9 zero-length job
    run_job(3, 0, 0, 503, 1'b1);   // R2 start pulse ignored while busy
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule